// File: doc/BRIEF.md
# Per-Thread Deadline Counter Unit

This block holds the timing hardware for a multithreaded core that must keep every task on a fixed schedule. Each hardware thread owns a private bank of down-counters. Decoded timing operations reach the block one at a time, each with a thread number, an operation code, a counter number and a load value. An operation can start a counter, stop it, load it, or make the thread wait on it.

A counter that is running loses one each clock. A wait holds the thread's stall line high until the chosen counter shows exactly one, so several threads given the same deadline come out of their waits together and can join. If a running counter reaches zero, the deadline has been missed. The thread is then suspended, the number of the counter that expired is latched, and an interrupt request is raised. The suspension remains until the thread's acknowledge line clears it.

Top module: `dl_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all stall, suspend, irq and violation index outputs are zero, and every counter is stopped at zero.
- R2: Operation codes are 0 = start, 1 = stop, 2 = load, 3 = wait. A started counter decrements by one each clock until it reaches zero. A stopped counter keeps its value and never causes a violation.
- R3: A load writes op_val_i into the selected counter. When a load and a decrement hit the same counter in the same cycle, the loaded value wins.
- R4: A wait raises the thread's stall from the cycle after the operation. Stall stays high until the selected counter holds 1, and falls in that same cycle. A stall never rises without a wait to that thread on the previous edge.
- R5: A running counter that holds zero at a clock edge sets its thread's suspend after that edge, stops the counter, and drops any pending wait of that thread. Stall is low on the cycle suspend rises.
- R6: Suspend is sticky. It clears only on an edge where susp_ack_i for that thread is high and no new violation occurs in that thread.
- R7: On a violation the index of the expired counter goes to the thread's field of viol_idx_o (thread t uses bits t*IDX_W and up). If several counters expire together, the lowest index is recorded. While the thread stays suspended without acknowledge, the recorded index does not change.
- R8: irq_o is high exactly when at least one thread is suspended.
- R9: An operation affects only the counters of the thread named by op_tid_i. When op_valid_i is low, the operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Timing operation present this cycle |
| op_tid_i | input | TID_W | Target thread |
| op_code_i | input | 2 | 0 start, 1 stop, 2 load, 3 wait |
| op_idx_i | input | IDX_W | Target counter within the thread |
| op_val_i | input | CNT_W | Value for a load |
| susp_ack_i | input | NUM_THREADS | Per-thread suspend acknowledge |
| stall_o | output | NUM_THREADS | Per-thread wait stall |
| suspend_o | output | NUM_THREADS | Per-thread sticky suspend |
| irq_o | output | 1 | Deadline violation interrupt request |
| viol_idx_o | output | NUM_THREADS*IDX_W | Per-thread index of the counter that expired |

## Verification
On every cycle, the assertions check that suspend is sticky and that the recorded index holds without acknowledge. They also check that a stall appears only after a wait to that thread, that stall is low when suspend rises, and that all outputs are quiet after reset. Other behaviour can only be shown by the bench's scenarios: the exact cycle on which a deadline expires, the release of a wait at a count of one, a load that beats a decrement, priority among counters that expire together, and isolation between threads. The bench checks these against a cycle model driven by both directed and seeded random operation streams.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_WAIT  = 2'd3
  } dl_op_e;
endpackage

// File: rtl/dl_counter.sv
module dl_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] value_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] value_q;
  logic             run_q;

  assign expired_o = run_q && (value_q == '0);
  assign value_o   = value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
      run_q   <= 1'b0;
    end else begin
      // load beats decrement
      if (load_i)                           value_q <= load_val_i;
      else if (run_q && value_q != '0)      value_q <= value_q - CNT_W'(1);
      // explicit op beats automatic stop on expiry
      if (start_i)                          run_q <= 1'b1;
      else if (stop_i)                      run_q <= 1'b0;
      else if (expired_o)                   run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dl_thread.sv
module dl_thread
  import dl_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = $clog2(NUM_CNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_hit_i,
  input  dl_op_e           op_code_i,
  input  logic [IDX_W-1:0] op_idx_i,
  input  logic [CNT_W-1:0] op_val_i,
  input  logic             ack_i,
  output logic             stall_o,
  output logic             suspend_o,
  output logic [IDX_W-1:0] viol_idx_o
);
  logic [CNT_W-1:0] cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_exp;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic sel;
    assign sel = op_hit_i && (op_idx_i == IDX_W'(g));
    dl_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (sel && op_code_i == OP_LOAD),
      .load_val_i (op_val_i),
      .start_i    (sel && op_code_i == OP_START),
      .stop_i     (sel && op_code_i == OP_STOP),
      .value_o    (cnt_val[g]),
      .expired_o  (cnt_exp[g])
    );
  end

  // lowest expired index wins
  logic             any_exp;
  logic [IDX_W-1:0] low_idx;
  always_comb begin
    any_exp = 1'b0;
    low_idx = '0;
    for (int i = NUM_CNT - 1; i >= 0; i--) begin
      if (cnt_exp[i]) begin
        any_exp = 1'b1;
        low_idx = IDX_W'(i);
      end
    end
  end

  logic             pend_q;
  logic [IDX_W-1:0] widx_q;
  logic             susp_q;
  logic [IDX_W-1:0] vidx_q;
  logic             at_one;

  assign at_one     = (cnt_val[widx_q] == CNT_W'(1));
  assign stall_o    = pend_q && !at_one;
  assign suspend_o  = susp_q;
  assign viol_idx_o = vidx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      widx_q <= '0;
      susp_q <= 1'b0;
      vidx_q <= '0;
    end else begin
      if (any_exp) begin
        pend_q <= 1'b0;
      end else if (op_hit_i && op_code_i == OP_WAIT) begin
        pend_q <= 1'b1;
        widx_q <= op_idx_i;
      end else if (pend_q && at_one) begin
        pend_q <= 1'b0;
      end
      susp_q <= any_exp || (susp_q && !ack_i);
      if (any_exp && (!susp_q || ack_i)) vidx_q <= low_idx;
    end
  end
endmodule

// File: rtl/dl_unit.sv
module dl_unit
  import dl_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 32,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int IDX_W      = $clog2(NUM_CNT)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         op_valid_i,
  input  logic [TID_W-1:0]             op_tid_i,
  input  logic [1:0]                   op_code_i,
  input  logic [IDX_W-1:0]             op_idx_i,
  input  logic [CNT_W-1:0]             op_val_i,
  input  logic [NUM_THREADS-1:0]       susp_ack_i,
  output logic [NUM_THREADS-1:0]       stall_o,
  output logic [NUM_THREADS-1:0]       suspend_o,
  output logic                         irq_o,
  output logic [NUM_THREADS*IDX_W-1:0] viol_idx_o
);
  dl_op_e op_code;
  assign op_code = dl_op_e'(op_code_i);

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    dl_thread #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_thr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_hit_i   (op_valid_i && (op_tid_i == TID_W'(g))),
      .op_code_i  (op_code),
      .op_idx_i   (op_idx_i),
      .op_val_i   (op_val_i),
      .ack_i      (susp_ack_i[g]),
      .stall_o    (stall_o[g]),
      .suspend_o  (suspend_o[g]),
      .viol_idx_o (viol_idx_o[g*IDX_W +: IDX_W])
    );
  end

  assign irq_o = |suspend_o;
endmodule

// File: rtl/dl_unit_chk.sv
module dl_unit_chk #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2,
  parameter int IDX_W       = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         op_valid_i,
  input logic [TID_W-1:0]             op_tid_i,
  input logic [1:0]                   op_code_i,
  input logic [NUM_THREADS-1:0]       susp_ack_i,
  input logic [NUM_THREADS-1:0]       stall_o,
  input logic [NUM_THREADS-1:0]       suspend_o,
  input logic                         irq_o,
  input logic [NUM_THREADS*IDX_W-1:0] viol_idx_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (suspend_o == '0 && stall_o == '0 && !irq_o && viol_idx_o == '0));

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_t
    a_r6_suspend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      suspend_o[g] && !susp_ack_i[g] |=> suspend_o[g]);

    a_r7_idx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      suspend_o[g] && !susp_ack_i[g] |=> $stable(viol_idx_o[g*IDX_W +: IDX_W]));

    a_r5_no_stall_on_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(suspend_o[g]) |-> !stall_o[g]);

    a_r4_stall_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stall_o[g]) |->
        $past(op_valid_i && op_tid_i == TID_W'(g) && op_code_i == 2'd3));
  end
endmodule

bind dl_unit dl_unit_chk #(
  .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_tid_i   (op_tid_i),
  .op_code_i  (op_code_i),
  .susp_ack_i (susp_ack_i),
  .stall_o    (stall_o),
  .suspend_o  (suspend_o),
  .irq_o      (irq_o),
  .viol_idx_o (viol_idx_o)
);

// File: tb/dl_unit_tb.sv
module dl_unit_tb;
  localparam int NT = 4;
  localparam int NC = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          op_valid_i = 1'b0;
  logic [1:0]    op_tid_i = '0;
  logic [1:0]    op_code_i = '0;
  logic [IW-1:0] op_idx_i = '0;
  logic [31:0]   op_val_i = '0;
  logic [NT-1:0] susp_ack_i = '0;
  logic [NT-1:0] stall_o, suspend_o;
  logic          irq_o;
  logic [NT*IW-1:0] viol_idx_o;

  always #2.5 clk = ~clk;

  dl_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_tid_i(op_tid_i),
    .op_code_i(op_code_i), .op_idx_i(op_idx_i), .op_val_i(op_val_i),
    .susp_ack_i(susp_ack_i), .stall_o(stall_o), .suspend_o(suspend_o),
    .irq_o(irq_o), .viol_idx_o(viol_idx_o)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] m_val [NT][NC];
  bit          m_run [NT][NC];
  bit          m_pend [NT];
  int          m_widx [NT];
  bit          m_susp [NT];
  int          m_vidx [NT];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      for (int c = 0; c < NC; c++) begin m_val[t][c] = '0; m_run[t][c] = 1'b0; end
      m_pend[t] = 0; m_widx[t] = 0; m_susp[t] = 0; m_vidx[t] = 0;
    end
  endtask

  task automatic model_edge(input bit v, input int tid, input int code, input int idx,
                            input logic [31:0] val, input logic [NT-1:0] ack);
    for (int t = 0; t < NT; t++) begin
      bit anyv = 0;
      int lo = 0;
      bit hit_t = v && tid == t;
      for (int c = NC - 1; c >= 0; c--)
        if (m_run[t][c] && m_val[t][c] == 0) begin anyv = 1; lo = c; end
      if (anyv) m_pend[t] = 0;
      else if (hit_t && code == 3) begin m_pend[t] = 1; m_widx[t] = idx; end
      else if (m_pend[t] && m_val[t][m_widx[t]] == 1) m_pend[t] = 0;
      if (anyv && (!m_susp[t] || ack[t])) m_vidx[t] = lo;
      m_susp[t] = anyv || (m_susp[t] && !ack[t]);
      for (int c = 0; c < NC; c++) begin
        bit hit = hit_t && idx == c;
        bit expd = m_run[t][c] && m_val[t][c] == 0;
        if (hit && code == 2) m_val[t][c] = val;
        else if (m_run[t][c] && m_val[t][c] != 0) m_val[t][c] = m_val[t][c] - 1;
        if (hit && code == 0) m_run[t][c] = 1;
        else if (hit && code == 1) m_run[t][c] = 0;
        else if (expd) m_run[t][c] = 0;
      end
    end
  endtask

  task automatic compare_all();
    logic [NT-1:0] e_stall, e_susp;
    logic [NT*IW-1:0] e_idx;
    for (int t = 0; t < NT; t++) begin
      e_stall[t] = m_pend[t] && m_val[t][m_widx[t]] != 1;
      e_susp[t]  = m_susp[t];
      e_idx[t*IW +: IW] = IW'(m_vidx[t]);
    end
    chk("R4 stall", 32'(stall_o), 32'(e_stall));
    chk("R5/R6 suspend", 32'(suspend_o), 32'(e_susp));
    chk("R7 viol_idx", 32'(viol_idx_o), 32'(e_idx));
    chk("R8 irq", 32'(irq_o), 32'(|e_susp));
  endtask

  task automatic cyc(input bit v, input int t, input int c, input int i,
                     input logic [31:0] val, input logic [NT-1:0] ack);
    op_valid_i = v; op_tid_i = 2'(t); op_code_i = 2'(c); op_idx_i = IW'(i);
    op_val_i = val; susp_ack_i = ack;
    @(posedge clk);
    model_edge(v, t, c, i, val, ack);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, '0);
  endtask

  task automatic do_reset();
    op_valid_i = 0; susp_ack_i = '0;
    rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // R1 reset state
    chk("R1 stall", 32'(stall_o), 0);
    chk("R1 suspend", 32'(suspend_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 viol_idx", 32'(viol_idx_o), 0);

    // R2/R5: load 2, start, expires on the third edge after start
    cyc(1, 1, 2, 2, 2, '0);
    cyc(1, 1, 0, 2, 0, '0);
    cyc(0, 0, 0, 0, 0, '0);
    chk("R2 no early violation", 32'(suspend_o[1]), 0);
    cyc(0, 0, 0, 0, 0, '0);
    chk("R2 no early violation", 32'(suspend_o[1]), 0);
    cyc(0, 0, 0, 0, 0, '0);
    chk("R5 suspend on expiry", 32'(suspend_o[1]), 1);
    chk("R7 index of expired counter", 32'(viol_idx_o[1*IW +: IW]), 2);
    idle(8);
    chk("R6 suspend sticky", 32'(suspend_o[1]), 1);
    cyc(0, 0, 0, 0, 0, 4'b0010);
    chk("R6 ack clears", 32'(suspend_o[1]), 0);

    // R2: stopped counter never violates
    do_reset();
    cyc(1, 0, 2, 0, 2, '0);
    cyc(1, 0, 0, 0, 0, '0);
    cyc(1, 0, 1, 0, 0, '0);
    idle(10);
    chk("R2 stopped counter quiet", 32'(suspend_o[0]), 0);

    // R3: reload before expiry
    do_reset();
    cyc(1, 2, 2, 1, 3, '0);
    cyc(1, 2, 0, 1, 0, '0);
    idle(2);
    cyc(1, 2, 2, 1, 8, '0);
    idle(6);
    chk("R3 load wins over decrement", 32'(suspend_o[2]), 0);

    // R4: wait release at one
    do_reset();
    cyc(1, 3, 2, 0, 4, '0);
    cyc(1, 3, 0, 0, 0, '0);
    cyc(1, 3, 3, 0, 0, '0);
    chk("R4 stall after wait", 32'(stall_o[3]), 1);
    cyc(0, 0, 0, 0, 0, '0);
    chk("R4 stall while above one", 32'(stall_o[3]), 1);
    cyc(0, 0, 0, 0, 0, '0);
    chk("R4 release at one", 32'(stall_o[3]), 0);
    cyc(1, 3, 2, 0, 10, '0);
    chk("R4 no violation after reload", 32'(suspend_o[3]), 0);

    // R7: simultaneous expiry picks lowest, first index held
    do_reset();
    cyc(1, 2, 2, 1, 1, '0);
    cyc(1, 2, 0, 1, 0, '0);
    cyc(1, 2, 0, 3, 0, '0);
    cyc(0, 0, 0, 0, 0, '0);
    chk("R7 lowest index", 32'(viol_idx_o[2*IW +: IW]), 1);
    cyc(1, 2, 0, 2, 0, '0);
    idle(2);
    chk("R7 first index held", 32'(viol_idx_o[2*IW +: IW]), 1);
    chk("R8 irq with suspend", 32'(irq_o), 1);

    // R9: invalid op ignored, valid op local to thread
    do_reset();
    cyc(0, 3, 0, 0, 0, '0);
    idle(3);
    chk("R9 invalid op ignored", 32'(suspend_o), 0);
    cyc(1, 3, 0, 0, 0, '0);
    idle(1);
    chk("R9 only target thread", 32'(suspend_o), 32'b1000);

    // random mix
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom % 4) != 0;
      int t = $urandom % NT;
      int c = $urandom % 4;
      int i = $urandom % NC;
      logic [31:0] val = 32'($urandom % 16);
      logic [NT-1:0] ack = '0;
      for (int k = 0; k < NT; k++) ack[k] = ($urandom % 8) == 0;
      cyc(v, t, c, i, val, ack);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule